// File: doc/BRIEF.md
# Configurable-frame serial transmitter

This block turns one data word into an asynchronous serial frame each time a start strobe is accepted. The frame shape (7, 8 or 9 data bits, optional odd or even parity, one or two stop bits) and the bit timing (a 16-bit divisor read as either an oversample-by-16 or an oversample-by-8 value) are chosen at run time by control inputs. The block makes its own bit-time tick from the divisor, so the bit period is counted directly in clock cycles.

All settings are captured on the accepted start edge and held for the whole frame. A start strobe that arrives while a frame is in flight is dropped. A strobe that arrives with an illegal setting starts nothing and raises an error flag instead. When the last stop bit ends, a one-cycle done strobe is given.

Top module: `uart_frame_tx`

## Requirements
- R1: The word-length code `cfg_wlen` selects 8 data bits for 2'b00, 9 for 2'b01 and 7 for 2'b10. Code 2'b11 is illegal.
- R2: A parity bit is sent only when `cfg_par_en` is 1. With `cfg_par_odd` = 1 the count of ones over data and parity is odd, and with 0 it is even.
- R3: Stop code `cfg_stop` 2'b00 sends one stop bit and 2'b10 sends two. Codes 2'b01 and 2'b11 are illegal.
- R4: With `cfg_over8` = 0 every bit lasts exactly `cfg_baud` clock cycles.
- R5: With `cfg_over8` = 1 every bit lasts {`cfg_baud`[15:4], `cfg_baud`[2:0]} clock cycles, that is half of the divisor built from bits 15:4 kept and bits 2:0 moved up one place. A set `cfg_baud`[3] is illegal in this mode.
- R6: A `cfg_baud` value below 16 is illegal in both modes.
- R7: A start strobe met while idle with any illegal setting starts no frame (the line stays high and no done strobe follows). `cfg_err` is 1 from the cycle after that strobe until the cycle after the next accepted start. It is 0 after reset.
- R8: The line is high while idle and after reset. A frame is a low start bit, then the data bits least significant first, then the parity bit if enabled, then the high stop bits. The start bit appears in the cycle after the accepted start edge.
- R9: If a start is accepted at clock edge k and the frame has n bits of period P, `tx_done` is 1 only in the cycle after edge k+n*P, for exactly one cycle. It is 0 after reset.
- R10: A start strobe while a frame is in flight is ignored: the current frame is neither restarted nor changed.
- R11: Changes to the data and control inputs after the accepted start edge do not change the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 9 | Data word; only the low 7, 8 or 9 bits are sent |
| tx_start | input | 1 | Start request, sampled on the clock edge |
| cfg_wlen | input | 2 | Word-length code (R1) |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Parity type: 1 odd, 0 even |
| cfg_stop | input | 2 | Stop-bit code (R3) |
| cfg_over8 | input | 1 | 1 selects the oversample-by-8 reading of the divisor |
| cfg_baud | input | 16 | Baud divisor field |
| tx_line | output | 1 | Serial output line, idle high |
| tx_done | output | 1 | One-cycle pulse after the last stop bit |
| cfg_err | output | 1 | Last start request was refused for an illegal setting |

## Verification
The assertions watch every cycle for the line being high whenever no frame is in flight, the start bit following an accepted request, a refused request leaving the block idle, a done pulse lasting one cycle right at the end of a frame, the bit counter staying below the captured period, the period holding still through a frame, and a strobe during a frame not cutting it short. What they cannot show is the frame contents and bit lengths against the settings: the bench sends constrained random and directed frames in both divisor modes, samples each bit in its middle against a model of its own, and places the done pulse to the cycle. The illegal codes, the divisor boundary at 16, and inputs changed or strobed mid-frame are covered only by bench scenarios.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  localparam int DATA_W   = 9;
  localparam int BAUD_W   = 16;
  localparam int MAX_STOP = 2;
  localparam int FRAME_W  = 1 + DATA_W + 1 + MAX_STOP;
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int NB_W     = $clog2(DATA_W + 1);
  localparam logic [BAUD_W-1:0] MIN_BAUD = BAUD_W'(16);

  typedef struct packed {
    logic [NB_W-1:0] nbits;
    logic            par_en;
    logic            par_odd;
    logic            two_stop;
  } frame_shape_t;

  // word-length code to data bit count; 0 marks the illegal code
  function automatic logic [NB_W-1:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'b00:   return NB_W'(8);
      2'b01:   return NB_W'(9);
      2'b10:   return NB_W'(7);
      default: return NB_W'(0);
    endcase
  endfunction

  function automatic logic cfg_legal(input logic [1:0] wl, input logic [1:0] stop,
                                     input logic over8, input logic [BAUD_W-1:0] baud);
    logic ok;
    ok = (wl != 2'b11);
    ok = ok && (stop == 2'b00 || stop == 2'b10);
    ok = ok && (baud >= MIN_BAUD);
    ok = ok && !(over8 && baud[3]);
    return ok;
  endfunction

  // bit time in clock cycles
  function automatic logic [BAUD_W-1:0] bit_period(input logic over8,
                                                   input logic [BAUD_W-1:0] baud);
    if (over8) return BAUD_W'({baud[BAUD_W-1:4], baud[2:0]});
    return baud;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input frame_shape_t s);
    return LEN_W'(1) + LEN_W'(s.nbits) + LEN_W'(s.par_en) +
           (s.two_stop ? LEN_W'(2) : LEN_W'(1));
  endfunction

  // whole frame, first bit on the line in position 0, padded with ones
  function automatic logic [FRAME_W-1:0] build_frame(input frame_shape_t s,
                                                     input logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] v;
    logic p;
    v    = '1;
    v[0] = 1'b0;
    p    = s.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(s.nbits)) begin
        v[i+1] = d[i];
        p      = p ^ d[i];
      end
    end
    if (s.par_en) v[int'(s.nbits)+1] = p;
    return v;
  endfunction

endpackage

// File: rtl/uftx_cfg_decode.sv
module uftx_cfg_decode
  import uftx_pkg::*;
(
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        stop,
  input  logic              over8,
  input  logic [BAUD_W-1:0] baud,
  output frame_shape_t      shape,
  output logic [BAUD_W-1:0] period,
  output logic              legal
);

  always_comb begin
    shape.nbits    = wlen_bits(wlen);
    shape.par_en   = par_en;
    shape.par_odd  = par_odd;
    shape.two_stop = stop[1];
    period         = bit_period(over8, baud);
    legal          = cfg_legal(wlen, stop, over8, baud);
  end

endmodule

// File: rtl/uftx_baud_gen.sv
module uftx_baud_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] load_period,
  output logic             tick
);

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else if (restart) begin
      period_q <= load_period;
      cnt_q    <= load_period - CNT_W'(1);
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= period_q - CNT_W'(1);
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign tick = run && !restart && (cnt_q == '0);

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < period_q));  // R4

  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(restart) && !restart) |-> $stable(period_q));  // R11

endmodule

// File: rtl/uftx_serializer.sv
module uftx_serializer
  import uftx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  frame_shape_t      shape,
  input  logic [DATA_W-1:0] data,
  input  logic              tick,
  output logic              line,
  output logic              busy,
  output logic              frame_end
);

  logic [FRAME_W-1:0] shreg_q;
  logic [LEN_W-1:0]   left_q;
  logic               busy_q;

  assign frame_end = busy_q && tick && (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (load) begin
      shreg_q <= build_frame(shape, data);
      left_q  <= frame_len(shape);
      busy_q  <= 1'b1;
    end else if (busy_q && tick) begin
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      left_q  <= left_q - LEN_W'(1);
      if (left_q == LEN_W'(1)) busy_q <= 1'b0;
    end
  end

  assign line = busy_q ? shreg_q[0] : 1'b1;
  assign busy = busy_q;

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> line);  // R8

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);  // R10

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8:0]        tx_data,
  input  logic              tx_start,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_over8,
  input  logic [15:0]       cfg_baud,
  output logic              tx_line,
  output logic              tx_done,
  output logic              cfg_err
);

  frame_shape_t      shape;
  logic [BAUD_W-1:0] period;
  logic              legal;
  logic              busy;
  logic              tick;
  logic              frame_end;
  logic              accept;
  logic              refuse;
  logic              done_q;
  logic              err_q;

  uftx_cfg_decode u_decode (
    .wlen    (cfg_wlen),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .stop    (cfg_stop),
    .over8   (cfg_over8),
    .baud    (cfg_baud),
    .shape   (shape),
    .period  (period),
    .legal   (legal)
  );

  // request events, brought out for the checks below
  assign accept = tx_start && !busy && legal;
  assign refuse = tx_start && !busy && !legal;

  uftx_baud_gen #(.CNT_W(BAUD_W)) u_baud (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (accept),
    .run         (busy),
    .load_period (period),
    .tick        (tick)
  );

  uftx_serializer u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .shape     (shape),
    .data      (tx_data),
    .tick      (tick),
    .line      (tx_line),
    .busy      (busy),
    .frame_end (frame_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= frame_end;
      if (accept)      err_q <= 1'b0;
      else if (refuse) err_q <= 1'b1;
    end
  end

  assign tx_done = done_q;
  assign cfg_err = err_q;

  AST_REFUSE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> (!busy && tx_line && cfg_err));  // R7

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !tx_line));  // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);  // R9

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> ($past(busy) && !busy));  // R9

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_start && !frame_end) |=> busy);  // R10

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        tx_start = 1'b0;
  logic [1:0]  cfg_wlen = '0;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_odd = 1'b0;
  logic [1:0]  cfg_stop = '0;
  logic        cfg_over8 = 1'b0;
  logic [15:0] cfg_baud = 16'd16;
  logic        tx_line;
  logic        tx_done;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_start(tx_start),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .cfg_over8(cfg_over8), .cfg_baud(cfg_baud),
    .tx_line(tx_line), .tx_done(tx_done), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bench model, written from the requirements
  function automatic int m_bits(input logic [1:0] wl);
    if (wl == 2'b10) return 7;
    if (wl == 2'b01) return 9;
    return 8;
  endfunction

  function automatic bit m_legal(input logic [1:0] wl, input logic [1:0] st,
                                 input logic o8, input logic [15:0] b);
    if (wl == 2'b11) return 0;
    if (st == 2'b01 || st == 2'b11) return 0;
    if (b < 16) return 0;
    if (o8 && b[3]) return 0;
    return 1;
  endfunction

  function automatic int m_period(input logic o8, input logic [15:0] b);
    int div;
    if (!o8) return int'(b);
    div = int'((b & 16'hFFF0) | ((b & 16'h0007) << 1));
    return div / 2;
  endfunction

  function automatic int m_len(input logic [1:0] wl, input logic pe, input logic [1:0] st);
    return 1 + m_bits(wl) + (pe ? 1 : 0) + (st == 2'b10 ? 2 : 1);
  endfunction

  function automatic logic m_bit(input int i, input logic [8:0] d, input logic [1:0] wl,
                                 input logic pe, input logic po);
    int w;
    int ones;
    w = m_bits(wl);
    if (i == 0) return 1'b0;
    if (i <= w) return d[i-1];
    if (pe && i == w + 1) begin
      ones = 0;
      for (int k = 0; k < w; k++) ones += int'(d[k]);
      return po ? ((ones % 2) == 0) : ((ones % 2) == 1);
    end
    return 1'b1;
  endfunction

  // send one legal frame and check every bit in its middle plus the done pulse;
  // with disturb set, inputs change and a start is pulsed mid-frame (R10, R11)
  task automatic run_frame(input logic [8:0] d, input logic [1:0] wl, input logic pe,
                           input logic po, input logic [1:0] st, input logic o8,
                           input logic [15:0] b, input bit disturb, input string tag);
    int p;
    int n;
    int bad;
    p = m_period(o8, b);
    n = m_len(wl, pe, st);
    bad = 0;
    @(negedge clk);
    tx_data = d; cfg_wlen = wl; cfg_par_en = pe; cfg_par_odd = po;
    cfg_stop = st; cfg_over8 = o8; cfg_baud = b; tx_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_start = 1'b0;
    for (int m = 0; m <= n * p; m++) begin
      if (m > 0) @(negedge clk);
      if (m == 0) check(cfg_err == 1'b0, "R7 err cleared on accept", int'(cfg_err), 0);
      if (m % p == p / 2 && m / p < n) begin
        if (tx_line !== m_bit(m / p, d, wl, pe, po)) begin
          bad++;
          $display("FAIL %s bit %0d: actual %0d expected %0d", tag, m / p,
                   int'(tx_line), int'(m_bit(m / p, d, wl, pe, po)));
        end
      end
      if (m == n * p - 1)
        check(tx_done == 1'b0, "R9 no early done", int'(tx_done), 0);
      if (m == n * p) begin
        check(tx_done == 1'b1, "R9 done after last stop", int'(tx_done), 1);
        check(tx_line == 1'b1, "R8 idle high after frame", int'(tx_line), 1);
      end
      if (disturb && m == p) begin
        tx_data = ~d; cfg_wlen = 2'b01; cfg_par_en = ~pe; cfg_par_odd = ~po;
        cfg_stop = 2'b00; cfg_baud = 16'd16; cfg_over8 = 1'b0; tx_start = 1'b1;
      end
      if (disturb && m == p + 1) tx_start = 1'b0;
    end
    checks++;
    if (bad != 0) errors++;
    @(negedge clk);
    check(tx_done == 1'b0, "R9 done lasts one cycle", int'(tx_done), 0);
  endtask

  task automatic refused(input logic [1:0] wl, input logic [1:0] st, input logic o8,
                         input logic [15:0] b, input string tag);
    int bad;
    bad = 0;
    @(negedge clk);
    tx_data = 9'h155; cfg_wlen = wl; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    cfg_stop = st; cfg_over8 = o8; cfg_baud = b; tx_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_start = 1'b0;
    check(cfg_err == 1'b1, tag, int'(cfg_err), 1);
    for (int m = 0; m < 40; m++) begin
      if (tx_line !== 1'b1 || tx_done !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R7 no frame on refusal", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_line == 1'b1, "R8 reset line high", int'(tx_line), 1);
    check(tx_done == 1'b0, "R9 reset done low", int'(tx_done), 0);
    check(cfg_err == 1'b0, "R7 reset err low", int'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    run_frame(9'h0A5, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 16'd16, 0, "R4 8N1 baud 16");
    run_frame(9'h05B, 2'b10, 1'b1, 1'b0, 2'b10, 1'b0, 16'd19, 0, "R1 R2 7E2");
    run_frame(9'h1C3, 2'b01, 1'b1, 1'b1, 2'b00, 1'b0, 16'd17, 0, "R1 R2 9O1");
    run_frame(9'h000, 2'b00, 1'b1, 1'b1, 2'b10, 1'b0, 16'd18, 0, "R2 odd all zero");
    run_frame(9'h0FF, 2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 16'd16, 0, "R2 even all ones");
    run_frame(9'h06C, 2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 16'h0017, 0, "R5 over8 period 15");
    run_frame(9'h139, 2'b01, 1'b0, 1'b0, 2'b10, 1'b1, 16'h0020, 0, "R5 over8 period 16");
    run_frame(9'h0C6, 2'b00, 1'b1, 1'b0, 2'b10, 1'b0, 16'd20, 1, "R10 R11 mid-frame changes");

    refused(2'b11, 2'b00, 1'b0, 16'd16, "R1 code 11 refused");
    refused(2'b00, 2'b01, 1'b0, 16'd16, "R3 stop 01 refused");
    refused(2'b00, 2'b11, 1'b0, 16'd16, "R3 stop 11 refused");
    refused(2'b00, 2'b00, 1'b0, 16'd15, "R6 baud 15 refused");
    refused(2'b00, 2'b00, 1'b1, 16'h0028, "R5 over8 bit3 refused");
    run_frame(9'h033, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 16'd16, 0, "R7 legal after refusal");

    // constrained random frames, fixed seed
    begin
      int seed;
      seed = $urandom(32'd20240917);
      for (int t = 0; t < 40; t++) begin
        logic [1:0]  wl;
        logic [1:0]  st;
        logic        o8;
        logic [15:0] b;
        wl = 2'($urandom_range(0, 2));
        st = ($urandom_range(0, 1) == 1) ? 2'b10 : 2'b00;
        o8 = 1'($urandom_range(0, 1));
        if (o8) b = 16'((($urandom_range(2, 5)) << 4) | $urandom_range(0, 7));
        else    b = 16'($urandom_range(16, 40));
        run_frame(9'($urandom), wl, 1'($urandom), 1'($urandom), st, o8, b,
                  ($urandom_range(0, 3) == 0), "R8 random frame");
      end
    end
    finish_run();
  end

endmodule